// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command, address, bank-address and clock-enable pins of a double-data-rate SDRAM from reset until the memory can accept normal traffic. It keeps the bus quiet while the supplies and clock settle. It then raises clock enable and steps through a fixed programming order: precharge of all banks, an extended mode write, a base mode write that resets the DLL, a second precharge of all banks, a parameterised number of auto refreshes, and a final base mode write that releases the DLL reset. Each command is followed by its own spacing.

All waits are counted by one shared down-counter, reloaded each time a step begins. Wait lengths come from nanosecond parameters rounded up to whole periods of the clock. A second counter starts at the DLL-reset write and measures the lock interval. The read-permitted flag therefore depends on that counter as well as on the end of the sequence, and it can rise later than init-done.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and after reset until `pwr_stable` is sampled high, `cke` is 0, `cmd_n` is NOP (4'b0111, bit order {CS#,RAS#,CAS#,WE#} from bit 3 down), `addr` and `ba` are 0, and `init_done` and `read_ok` are 0.
- R2: The first clock edge that samples `pwr_stable` high starts the sequence. For the SETTLE_NS interval in cycles (rounded up) that follows, `cke` stays 0 and the bus carries NOP. After that, `cke` is 1 for CKE_LEAD_CYC NOP cycles before the first command, and `cke` never falls again until reset.
- R3: Commands appear in this order: precharge, extended mode write, mode write with DLL reset, precharge, NUM_REFRESH auto refreshes (at least 2), mode write without DLL reset. The encodings are precharge 4'b0010, auto refresh 4'b0001 and mode write 4'b0000. Each command lasts exactly one cycle.
- R4: A precharge drives `addr` with only bit 10 set and `ba`=0. The extended mode write drives EMR_VALUE with `ba`=1. Both base mode writes drive MR_VALUE with `ba`=0, with bit 8 forced to 1 in the first and to 0 in the last. NOP and auto refresh cycles drive `addr`=0 and `ba`=0.
- R5: The next command follows a precharge after the tRP count and follows a mode write after the tMRD count. It follows an auto refresh after the tRFC count. Each count is the nanosecond parameter divided by CLK_PS and rounded up, or TMRD_CYC for tMRD, and is never below 2. The bus carries NOP in between.
- R6: `init_done` rises exactly tMRD cycles after the final mode write and then stays high with the bus at NOP and `cke` at 1.
- R7: `read_ok` rises in whichever cycle comes later: the one where `init_done` rises, or DLL_LOCK_CYC cycles after the DLL-reset mode write. It is never high while `init_done` is low.
- R8: Once the sequence has started, `pwr_stable` is ignored. Dropping it changes no output and does not alter the schedule.
- R9: Asserting reset in the middle of the sequence returns every output to the R1 state at once. A later start repeats the full sequence from the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock reported stable, synchronous to clk |
| cke | output | 1 | Clock enable to the memory |
| cmd_n | output | 4 | Encoded command {CS#,RAS#,CAS#,WE#} |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization sequence complete |
| read_ok | output | 1 | Read commands may be issued |

## Verification
The assertions assume that `pwr_stable` is synchronous to `clk` and that reset is asserted whenever the supplies are not valid, so the sequencer never leaves its idle state on a glitch. They also assume that the parameter clamps of R5 hold, which gives every command a gap of at least two cycles. The stimulus changes `pwr_stable` and `rst_n` only away from rising edges. It holds reset across a mid-sequence abort, and it drops `pwr_stable` only after the start has been sampled, in order to show that the input is ignored from then on.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CKE,
      ST_PRE_A,
      ST_EMRS,
      ST_MRS_DLL,
      ST_PRE_B,
      ST_REF,
      ST_MRS_RUN,
      ST_DONE
   } step_e;

   typedef logic [3:0] cmd_t;

   // {CS#, RAS#, CAS#, WE#}
   localparam cmd_t CMD_NOP = 4'b0111;
   localparam cmd_t CMD_PRE = 4'b0010;
   localparam cmd_t CMD_REF = 4'b0001;
   localparam cmd_t CMD_MRS = 4'b0000;

   // nanoseconds to whole clock cycles, rounded up, never below lo
   function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned clk_ps,
                                             int unsigned lo);
      longint unsigned c;
      c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
      return (c < lo) ? lo : int'(c);
   endfunction

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_RELOAD_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired) else $error("timer reload lost"); // R5

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int unsigned SETTLE_CYC   = 25000,
   parameter int unsigned CKE_LEAD_CYC = 2,
   parameter int unsigned TRP_CYC      = 2,
   parameter int unsigned TMRD_CYC     = 2,
   parameter int unsigned TRFC_CYC     = 10,
   parameter int unsigned NUM_REFRESH  = 2,
   parameter int unsigned CNT_W        = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_stable,
   input  logic             timer_zero,
   output step_e            step,
   output logic             first,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   localparam int unsigned REF_W = $clog2(NUM_REFRESH);
   localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REFRESH - 1);

   step_e            step_q, step_d;
   logic             first_q;
   logic [REF_W-1:0] ref_q, ref_d;
   logic             go;

   function automatic int unsigned dur_of(step_e s);
      case (s)
         ST_SETTLE:                       return SETTLE_CYC;
         ST_CKE:                          return CKE_LEAD_CYC;
         ST_PRE_A, ST_PRE_B:              return TRP_CYC;
         ST_EMRS, ST_MRS_DLL, ST_MRS_RUN: return TMRD_CYC;
         ST_REF:                          return TRFC_CYC;
         default:                         return 1;
      endcase
   endfunction

   always_comb begin
      step_d = step_q;
      ref_d  = ref_q;
      go     = 1'b0;
      case (step_q)
         ST_IDLE: begin
            if (pwr_stable) begin
               step_d = ST_SETTLE;
               go     = 1'b1;
            end
         end
         ST_DONE: begin
            go = 1'b0;
         end
         default: begin
            if (timer_zero) begin
               go = 1'b1;
               case (step_q)
                  ST_SETTLE:  step_d = ST_CKE;
                  ST_CKE:     step_d = ST_PRE_A;
                  ST_PRE_A:   step_d = ST_EMRS;
                  ST_EMRS:    step_d = ST_MRS_DLL;
                  ST_MRS_DLL: step_d = ST_PRE_B;
                  ST_PRE_B: begin
                     step_d = ST_REF;
                     ref_d  = '0;
                  end
                  ST_REF: begin
                     if (ref_q == REF_LAST) begin
                        step_d = ST_MRS_RUN;
                     end else begin
                        ref_d = ref_q + 1'b1;
                     end
                  end
                  ST_MRS_RUN: step_d = ST_DONE;
                  default:    step_d = ST_IDLE;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= ST_IDLE;
         first_q <= 1'b0;
         ref_q   <= '0;
      end else begin
         step_q  <= step_d;
         first_q <= go;
         ref_q   <= ref_d;
      end
   end

   assign step     = step_q;
   assign first    = first_q;
   assign load     = go;
   assign load_val = CNT_W'(dur_of(step_d) - 1);

   AST_HOLD_UNTIL_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_IDLE && step_q != ST_DONE && !timer_zero)
      |=> (step_q == $past(step_q) && !first_q)) else $error("step left early"); // R5

   AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_REF) |-> (ref_q <= REF_LAST)) else $error("refresh overrun"); // R3

   AST_EMRS_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_EMRS && first_q) |-> ($past(step_q) == ST_PRE_A)) else $error("order"); // R3

   AST_DONE_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_DONE) |=> (step_q == ST_DONE)) else $error("left done"); // R6

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
#(
   parameter int unsigned         ADDR_W    = 13,
   parameter int unsigned         BA_W      = 2,
   parameter int unsigned         DLL_BIT   = 8,
   parameter int unsigned         AP_BIT    = 10,
   parameter logic [ADDR_W-1:0]   MR_VALUE  = '0,
   parameter logic [ADDR_W-1:0]   EMR_VALUE = '0
) (
   input  step_e             step,
   input  logic              first,
   output cmd_t              cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);

   localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

   logic [ADDR_W-1:0] mr_dll;
   logic [ADDR_W-1:0] mr_run;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i == DLL_BIT) begin : g_dll
         assign mr_dll[i] = 1'b1;
         assign mr_run[i] = 1'b0;
      end else begin : g_keep
         assign mr_dll[i] = MR_VALUE[i];
         assign mr_run[i] = MR_VALUE[i];
      end
   end

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = '0;
      if (first) begin
         case (step)
            ST_PRE_A, ST_PRE_B: begin
               cmd  = CMD_PRE;
               addr = PRE_ADDR;
            end
            ST_EMRS: begin
               cmd  = CMD_MRS;
               addr = EMR_VALUE;
               ba   = BA_W'(1);
            end
            ST_MRS_DLL: begin
               cmd  = CMD_MRS;
               addr = mr_dll;
            end
            ST_REF: begin
               cmd  = CMD_REF;
            end
            ST_MRS_RUN: begin
               cmd  = CMD_MRS;
               addr = mr_run;
            end
            default: begin
               cmd  = CMD_NOP;
            end
         endcase
      end
   end

endmodule

// File: rtl/ddr_init_dll_lock.sv
module ddr_init_dll_lock #(
   parameter int unsigned LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (start) begin
         armed_q <= 1'b1;
      end
   end

   if (LOCK_CYC == 1) begin : g_direct
      assign locked = armed_q;
   end else begin : g_count
      localparam int unsigned W = $clog2(LOCK_CYC);
      logic [W-1:0] rem_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
         end else if (start) begin
            rem_q <= W'(LOCK_CYC - 1);
         end else if (armed_q && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
         end
      end
      assign locked = armed_q && (rem_q == '0);
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked) else $error("lock dropped"); // R7

   AST_LOCK_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> armed_q) else $error("lock without start"); // R7

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int unsigned       CLK_PS       = 8000,
   parameter int unsigned       SETTLE_NS    = 200000,
   parameter int unsigned       CKE_LEAD_CYC = 2,
   parameter int unsigned       TRP_NS       = 15,
   parameter int unsigned       TMRD_CYC     = 2,
   parameter int unsigned       TRFC_NS      = 75,
   parameter int unsigned       NUM_REFRESH  = 2,
   parameter int unsigned       DLL_LOCK_CYC = 200,
   parameter int unsigned       ADDR_W       = 13,
   parameter int unsigned       BA_W         = 2,
   parameter logic [ADDR_W-1:0] MR_VALUE     = ADDR_W'('h062),
   parameter logic [ADDR_W-1:0] EMR_VALUE    = ADDR_W'('h000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_stable,
   output logic              cke,
   output logic [3:0]        cmd_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done,
   output logic              read_ok
);

   localparam int unsigned DLL_BIT   = 8;
   localparam int unsigned AP_BIT    = 10;
   localparam int unsigned SETTLE_C  = ns_to_cyc(SETTLE_NS, CLK_PS, 1);
   localparam int unsigned TRP_C     = ns_to_cyc(TRP_NS, CLK_PS, 2);
   localparam int unsigned TRFC_C    = ns_to_cyc(TRFC_NS, CLK_PS, 2);
   localparam int unsigned TMRD_C    = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
   localparam int unsigned MAX_DUR   = max2(max2(SETTLE_C, CKE_LEAD_CYC),
                                            max2(max2(TRP_C, TMRD_C), TRFC_C));
   localparam int unsigned CNT_W     = $clog2(MAX_DUR);

   initial begin : p_params
      AST_PARAM_REFRESH: assert (NUM_REFRESH >= 2) else $error("NUM_REFRESH < 2"); // R3
      AST_PARAM_ADDR: assert (ADDR_W > AP_BIT && BA_W >= 1) else $error("bus too narrow"); // R4
      AST_PARAM_LEAD: assert (CKE_LEAD_CYC >= 1 && DLL_LOCK_CYC >= 1) else $error("zero count"); // R2
   end

   step_e            step;
   logic             first;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             timer_zero;
   logic             locked;
   cmd_t             cmd;

   ddr_init_fsm #(
      .SETTLE_CYC   (SETTLE_C),
      .CKE_LEAD_CYC (CKE_LEAD_CYC),
      .TRP_CYC      (TRP_C),
      .TMRD_CYC     (TMRD_C),
      .TRFC_CYC     (TRFC_C),
      .NUM_REFRESH  (NUM_REFRESH),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_stable (pwr_stable),
      .timer_zero (timer_zero),
      .step       (step),
      .first      (first),
      .load       (load),
      .load_val   (load_val)
   );

   ddr_init_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (timer_zero)
   );

   ddr_init_cmd_enc #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .DLL_BIT   (DLL_BIT),
      .AP_BIT    (AP_BIT),
      .MR_VALUE  (MR_VALUE),
      .EMR_VALUE (EMR_VALUE)
   ) u_enc (
      .step  (step),
      .first (first),
      .cmd   (cmd),
      .addr  (addr),
      .ba    (ba)
   );

   ddr_init_dll_lock #(
      .LOCK_CYC (DLL_LOCK_CYC)
   ) u_dll (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (first && step == ST_MRS_DLL),
      .locked (locked)
   );

   assign cmd_n     = cmd;
   assign cke       = (step != ST_IDLE) && (step != ST_SETTLE);
   assign init_done = (step == ST_DONE);
   assign read_ok   = init_done && locked;

   AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n != CMD_NOP) |-> cke) else $error("command with cke low"); // R2

   AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke) else $error("cke fell"); // R2

   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n == CMD_PRE) |-> (addr[AP_BIT] && ba == '0)) else $error("precharge not all"); // R4

   AST_CMD_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n != CMD_NOP) |=> (cmd_n == CMD_NOP)) else $error("back-to-back command"); // R5

   AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd_n == CMD_NOP && cke)) else $error("bus busy after done"); // R6

   AST_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      read_ok |-> init_done) else $error("read before done"); // R7

endmodule

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;

   localparam int CLK_PS   = 8000;
   localparam int SET_NS   = 400;
   localparam int LEAD     = 2;
   localparam int TRP_NS   = 15;
   localparam int TMRD     = 2;
   localparam int TRFC_NS  = 75;
   localparam int NREF     = 3;
   localparam int DLL      = 200;
   localparam logic [12:0] MRV  = 13'h0563;
   localparam logic [12:0] EMRV = 13'h0002;

   // expected cycle counts, rounded up from nanoseconds
   localparam int S    = (SET_NS * 1000 + CLK_PS - 1) / CLK_PS;   // 50
   localparam int TRP  = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;   // 2
   localparam int TRFC = (TRFC_NS * 1000 + CLK_PS - 1) / CLK_PS;  // 10

   localparam int T_PRE1 = S + LEAD;
   localparam int T_EMRS = T_PRE1 + TRP;
   localparam int T_MRSD = T_EMRS + TMRD;
   localparam int T_PRE2 = T_MRSD + TMRD;
   localparam int T_REF0 = T_PRE2 + TRP;
   localparam int T_MRS  = T_REF0 + NREF * TRFC;
   localparam int T_DONE = T_MRS + TMRD;
   localparam int T_RD   = (T_MRSD + DLL > T_DONE) ? T_MRSD + DLL : T_DONE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_stable = 1'b0;
   logic        cke;
   logic [3:0]  cmd_n;
   logic [12:0] addr;
   logic [1:0]  ba;
   logic        init_done;
   logic        read_ok;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   ddr_init_seq #(
      .CLK_PS       (CLK_PS),
      .SETTLE_NS    (SET_NS),
      .CKE_LEAD_CYC (LEAD),
      .TRP_NS       (TRP_NS),
      .TMRD_CYC     (TMRD),
      .TRFC_NS      (TRFC_NS),
      .NUM_REFRESH  (NREF),
      .DLL_LOCK_CYC (DLL),
      .ADDR_W       (13),
      .BA_W         (2),
      .MR_VALUE     (MRV),
      .EMR_VALUE    (EMRV)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_stable (pwr_stable),
      .cke        (cke),
      .cmd_n      (cmd_n),
      .addr       (addr),
      .ba         (ba),
      .init_done  (init_done),
      .read_ok    (read_ok)
   );

   // {cke, cmd_n, ba, addr, init_done, read_ok}; n < 0 means idle
   function automatic logic [21:0] exp_vec(int n);
      logic       k, d, r;
      logic [3:0] c;
      logic [1:0] b;
      logic [12:0] a;
      k = (n >= S);
      c = 4'b0111; b = 2'b00; a = 13'h0;
      if (n == T_PRE1 || n == T_PRE2) begin c = 4'b0010; a = 13'h0400; end
      else if (n == T_EMRS) begin c = 4'b0000; a = EMRV; b = 2'b01; end
      else if (n == T_MRSD) begin c = 4'b0000; a = MRV | 13'h0100; end
      else if (n == T_MRS)  begin c = 4'b0000; a = MRV & ~13'h0100; end
      else begin
         for (int i = 0; i < NREF; i++) if (n == T_REF0 + i * TRFC) c = 4'b0001;
      end
      d = (n >= T_DONE);
      r = (n >= T_RD);
      return {k, c, b, a, d, r};
   endfunction

   function automatic string tag_of(int n);
      if (n < 0) return "R1";
      if (n < T_PRE1) return "R2";
      if (n >= T_RD) return "R7";
      if (n >= T_DONE) return "R6";
      if (exp_vec(n)[20:17] != 4'b0111) return "R3 R4";
      return "R5";
   endfunction

   task automatic check(string req, int n);
      logic [21:0] act, exp;
      act = {cke, cmd_n, ba, addr, init_done, read_ok};
      exp = exp_vec(n);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, n, act, exp);
      end
   endtask

   // R1: reset state and idle while pwr_stable is low
   task automatic t_reset_idle();
      rst_n = 1'b0; pwr_stable = 1'b0;
      repeat (3) begin @(posedge clk); #2; check("R1 reset", -1); end
      @(negedge clk); rst_n = 1'b1;
      repeat (10) begin @(posedge clk); #2; check("R1 idle", -1); end
   endtask

   // R2..R7 full schedule; R8 when pwr_stable is dropped after the start
   task automatic t_sequence(bit drop, string extra);
      @(negedge clk); pwr_stable = 1'b1;
      for (int n = 0; n <= T_RD + 8; n++) begin
         @(posedge clk); #2;
         if (drop && n == 5) pwr_stable = 1'b0;
         check({tag_of(n), extra}, n);
      end
      @(negedge clk); pwr_stable = 1'b0;
   endtask

   task automatic go_idle();
      @(negedge clk); rst_n = 1'b0; pwr_stable = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   // R9: abort by reset after the extended mode write, then restart
   task automatic t_mid_reset();
      @(negedge clk); pwr_stable = 1'b1;
      repeat (T_EMRS + 3) @(posedge clk);
      @(negedge clk); rst_n = 1'b0;
      #1 check("R9 abort", -1);
      repeat (2) begin @(posedge clk); #2; check("R9 held", -1); end
      @(negedge clk); pwr_stable = 1'b0; rst_n = 1'b1;
      repeat (3) begin @(posedge clk); #2; check("R9 idle", -1); end
      t_sequence(1'b0, " R9 restart");
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin : p_main
      t_reset_idle();
      t_sequence(1'b0, "");
      go_idle();
      t_sequence(1'b1, " R8");
      go_idle();
      t_mid_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule